// File: doc/BRIEF.md
# Serial Character Transmitter with Buffer-Level Status

This block turns characters written into a data register into asynchronous serial frames on a single output line. Written characters wait in a two-entry holding buffer. A frame sequencer takes them one at a time and shifts them out. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop period of half, one or two bit times. Between frames the line idles high.

Bit timing comes from an external baud generator. That generator delivers a one-cycle `half_tick` pulse twice per bit period. Half-bit resolution is what makes the half-length stop period possible.

Software drives the block through one-shot enable and disable commands and a frame-format word. It sees a level flag that reports room in the buffer at a selectable threshold, a transmit-complete flag, and the current enable state. A disable command never cuts a frame short, and it does not discard characters that are still buffered.

Top module: `serial_tx`

## Requirements
- R1: After synchronous reset, `txd` is 1, `tx_on` is 0, `tx_done` is 1 and `buf_lvl` is 1.
- R2: A frame is, in order: a start bit at 0, the data bits least significant first, the parity bit if enabled, and a stop period at 1. Whenever no frame is in progress, `txd` is 1.
- R3: `cfg[3:0]` holds the data-bit count minus 3. The values 2, 3, 4 and 5 select 5, 6, 7 and 8 data bits. Data bits above the selected count are not sent.
- R4: `cfg[9:8]` selects parity: 00 none, 10 even, 11 odd. Parity is taken over the sent data bits only. With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number.
- R5: Every bit lasts two `half_tick` pulses. The stop period lasts 1, 2 or 4 pulses for `cfg[13:12]` = 00, 01 or 11. A frame starts only on a `half_tick` pulse. The time from the start-bit falling edge to `tx_done` rising is (2·(1+data+parity)+stop pulses) × the pulse spacing.
- R6: The holding buffer keeps two characters. A write arriving while it is full is dropped.
- R7: With `lvl_sel` = 0, `buf_lvl` is 1 when at least one entry is free. With `lvl_sel` = 1, it is 1 only when the buffer is empty. It follows the fill level and needs no clear.
- R8: `tx_done` is 1 exactly when the buffer is empty and no frame is in progress.
- R9: A `cmd_en` pulse sets `tx_on` one cycle later, and a `cmd_dis` pulse clears it one cycle later. If both arrive in the same cycle, disable wins.
- R10: After a disable, the frame in progress completes and no new frame starts. Characters still in the buffer stay there and are sent after the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Character to send |
| cfg | input | 14 | Frame format: [3:0] data count − 3, [9:8] parity, [13:12] stop length |
| lvl_sel | input | 1 | Buffer-level threshold select |
| cmd_en | input | 1 | One-shot transmitter enable |
| cmd_dis | input | 1 | One-shot transmitter disable |
| half_tick | input | 1 | Pulse at twice the bit rate |
| txd | output | 1 | Serial output, idle high |
| buf_lvl | output | 1 | Buffer-level flag |
| tx_done | output | 1 | Buffer empty and shifter idle |
| tx_on | output | 1 | Current enable state |

## Verification
A write changes the fill level, and with it `buf_lvl` and `tx_done`, one clock later. A command changes `tx_on` one clock later. The bench samples all three on the falling edge that follows the write or the pulse. The start bit appears one clock after the `half_tick` that loads it, and `tx_done` rises one clock after the last stop pulse. Because both edges carry the same one-register delay, the bench measures frame length from the observed falling edge and expects an exact multiple of the pulse spacing. Each data, parity and stop bit is sampled at a fixed offset from that falling edge, half a bit in, so no check depends on which clock within a bit the design happens to switch.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DW    = 8;   // widest character
    localparam int CFG_W = 14;  // frame-format word width

    typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD} par_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
    } phase_e;

    typedef struct packed {
        logic [3:0] nbits;    // data bits per frame, 5..8
        par_e       par;
        logic [2:0] stop_ht;  // stop length in half-bit pulses: 1, 2 or 4
    } frame_t;

    function automatic frame_t decode_cfg(input logic [CFG_W-1:0] c);
        frame_t f;
        if (c[3:0] >= 4'd2 && c[3:0] <= 4'd5) f.nbits = c[3:0] + 4'd3;
        else                                  f.nbits = 4'd8;
        if (c[9])       f.par = c[8] ? PAR_ODD : PAR_EVEN;
        else            f.par = PAR_NONE;
        if (c[13])      f.stop_ht = 3'd4;
        else if (c[12]) f.stop_ht = 3'd2;
        else            f.stop_ht = 3'd1;
        return f;
    endfunction

    function automatic logic parity_bit(input logic [DW-1:0] d, input frame_t f);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++)
            if (i < int'(f.nbits)) m[i] = 1'b1;
        return (^(d & m)) ^ (f.par == PAR_ODD);
    endfunction

endpackage

// File: rtl/sertx_buf.sv
module sertx_buf
    import sertx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [DW-1:0]                 din,
    input  logic                          pop,
    output logic [DW-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R6: a write to a full buffer with no pop leaves the level unchanged
    a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> $stable(count));
    // R6: level never exceeds the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/sertx_enable.sv
module sertx_enable (
    input  logic clk,
    input  logic rst,
    input  logic cmd_en,
    input  logic cmd_dis,
    output logic on
);
    always_ff @(posedge clk) begin
        if (rst)          on <= 1'b0;
        else if (cmd_dis) on <= 1'b0;
        else if (cmd_en)  on <= 1'b1;
    end

    a_r9_dis_wins: assert property (@(posedge clk) disable iff (rst)
        cmd_dis |=> !on);
    a_r9_enable: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && !cmd_dis) |=> on);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  frame_t        cfg,
    output logic          busy,
    output logic          txd
);
    phase_e        ph;
    frame_t        fr;
    logic [DW-1:0] sh;
    logic [3:0]    bitn;
    logic [2:0]    hc;
    logic          pbit;

    assign busy = (ph != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            txd  <= 1'b1;
            fr   <= '0;
            sh   <= '0;
            bitn <= '0;
            hc   <= '0;
            pbit <= 1'b0;
        end else if (ph == PH_IDLE) begin
            if (load) begin
                ph   <= PH_START;
                fr   <= cfg;
                sh   <= din;
                pbit <= parity_bit(din, cfg);
                bitn <= '0;
                hc   <= 3'd2;
                txd  <= 1'b0;
            end
        end else if (tick) begin
            if (hc != 3'd1) begin
                hc <= hc - 3'd1;
            end else begin
                hc <= 3'd2;
                case (ph)
                    PH_START: begin
                        ph  <= PH_DATA;
                        txd <= sh[0];
                    end
                    PH_DATA: begin
                        if (bitn == fr.nbits - 4'd1) begin
                            if (fr.par != PAR_NONE) begin
                                ph  <= PH_PAR;
                                txd <= pbit;
                            end else begin
                                ph  <= PH_STOP;
                                txd <= 1'b1;
                                hc  <= fr.stop_ht;
                            end
                        end else begin
                            bitn <= bitn + 4'd1;
                            sh   <= sh >> 1;
                            txd  <= sh[1];
                        end
                    end
                    PH_PAR: begin
                        ph  <= PH_STOP;
                        txd <= 1'b1;
                        hc  <= fr.stop_ht;
                    end
                    default: begin
                        ph  <= PH_IDLE;
                        txd <= 1'b1;
                    end
                endcase
            end
        end
    end

    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);
    a_r5_load_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick));

endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import sertx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [CFG_W-1:0] cfg,
    input  logic             lvl_sel,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             half_tick,
    output logic             txd,
    output logic             buf_lvl,
    output logic             tx_done,
    output logic             tx_on
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0] level;
    logic [DW-1:0] head;
    logic          busy, start;
    frame_t        fcfg;

    assign fcfg  = decode_cfg(cfg);
    assign start = half_tick && !busy && tx_on && (level != '0);

    sertx_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .push(wr_en), .din(wr_data),
        .pop(start), .dout(head), .count(level)
    );

    sertx_enable u_en (
        .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_dis(cmd_dis), .on(tx_on)
    );

    sertx_shift u_sh (
        .clk(clk), .rst(rst), .tick(half_tick), .load(start),
        .din(head), .cfg(fcfg), .busy(busy), .txd(txd)
    );

    assign buf_lvl = lvl_sel ? (level == '0) : (level < CW'(DEPTH));
    assign tx_done = (level == '0) && !busy;

    // R10: while disabled, an idle shifter stays idle
    a_r10_off_no_start: assert property (@(posedge clk) disable iff (rst)
        (!tx_on && !busy) |=> !busy);
    // R8: transmit complete implies an idle line
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> txd);
    // R7: an empty buffer satisfies either threshold
    a_r7_done_level: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> buf_lvl);

endmodule

// File: tb/serial_tx_tb.sv
module serial_tx_tb;
    localparam int TP = 4;  // clocks between half_tick pulses

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [13:0] cfg = '0;
    logic        lvl_sel = 1'b0;
    logic        cmd_en = 1'b0, cmd_dis = 1'b0;
    logic        half_tick = 1'b0;
    logic        txd, buf_lvl, tx_done, tx_on;

    int n_chk = 0, n_err = 0, cyc = 0, tcnt = 0;

    always #2.5 clk = ~clk;

    serial_tx u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cfg(cfg),
        .lvl_sel(lvl_sel), .cmd_en(cmd_en), .cmd_dis(cmd_dis),
        .half_tick(half_tick), .txd(txd), .buf_lvl(buf_lvl),
        .tx_done(tx_done), .tx_on(tx_on)
    );

    always @(negedge clk) begin
        if (tcnt == TP-1) begin tcnt <= 0; half_tick <= 1'b1; end
        else begin tcnt <= tcnt + 1; half_tick <= 1'b0; end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [13:0] mkcfg(input int nb, input int pm, input int st);
        logic [13:0] c = '0;
        c[3:0]   = 4'(nb - 3);
        c[9:8]   = 2'(pm);
        c[13:12] = 2'(st);
        return c;
    endfunction

    task automatic write_ch(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_en();
        @(negedge clk); cmd_en = 1'b1;
        @(negedge clk); cmd_en = 1'b0;
    endtask

    task automatic pulse_dis();
        @(negedge clk); cmd_dis = 1'b1;
        @(negedge clk); cmd_dis = 1'b0;
    endtask

    // Decode one frame; sh = stop length in half-bit pulses
    task automatic rx_frame(input logic [7:0] d, input int nb, input int pm,
                            input int sh, input bit len_chk, input string req);
        logic [11:0] eb = '0;
        int nsamp, off, w;
        logic [7:0] m;
        m = 8'((9'd1 << nb) - 9'd1);
        for (int i = 0; i < nb; i++) eb[1+i] = d[i];
        nsamp = 1 + nb;
        if (pm != 0) begin
            eb[nsamp] = (^(d & m)) ^ (pm == 3);
            nsamp++;
        end
        w = 0;
        while (txd !== 1'b0 && w < 3000) begin @(negedge clk); w++; end
        chk(w < 3000, {req, " start seen"}, w, 0);
        off = 0;
        for (int k = 0; k < nsamp; k++) begin
            while (off < TP + 2*TP*k) begin @(negedge clk); off++; end
            chk(txd === eb[k], req, int'(txd), int'(eb[k]));
        end
        while (off < 2*TP*nsamp + 1) begin @(negedge clk); off++; end
        chk(txd === 1'b1, {req, " stop"}, int'(txd), 1);
        if (len_chk) begin
            while (!tx_done && off < 3000) begin @(negedge clk); off++; end
            chk(off == (2*nsamp + sh)*TP, {req, " R5 length"}, off, (2*nsamp + sh)*TP);
        end
    endtask

    task automatic t_reset();
        chk(txd == 1'b1,     "R1 txd",     int'(txd), 1);
        chk(tx_on == 1'b0,   "R1 tx_on",   int'(tx_on), 0);
        chk(tx_done == 1'b1, "R1 tx_done", int'(tx_done), 1);
        chk(buf_lvl == 1'b1, "R1 buf_lvl", int'(buf_lvl), 1);
    endtask

    task automatic t_basic();
        pulse_en();
        chk(tx_on == 1'b1, "R9 enable", int'(tx_on), 1);
        cfg = mkcfg(8, 0, 1);
        write_ch(8'hA5);
        rx_frame(8'hA5, 8, 0, 2, 1'b1, "R2 8N1");
    endtask

    task automatic t_formats();
        cfg = mkcfg(5, 2, 3);
        write_ch(8'hF3);
        rx_frame(8'hF3, 5, 2, 4, 1'b1, "R3 R4 5E2");
        cfg = mkcfg(7, 3, 0);
        write_ch(8'hD5);
        rx_frame(8'hD5, 7, 3, 1, 1'b1, "R4 R5 7O half");
        cfg = mkcfg(6, 0, 1);
        write_ch(8'h2C);
        rx_frame(8'h2C, 6, 0, 2, 1'b1, "R3 6N1");
        cfg = mkcfg(8, 2, 1);
        write_ch(8'h81);
        rx_frame(8'h81, 8, 2, 2, 1'b1, "R4 8E1");
    endtask

    task automatic t_level_drop();
        bit quiet = 1'b1;
        cfg = mkcfg(8, 0, 1);
        pulse_dis();
        chk(tx_on == 1'b0, "R9 disable", int'(tx_on), 0);
        lvl_sel = 1'b1; #1;
        chk(buf_lvl == 1'b1, "R7 empty sel1", int'(buf_lvl), 1);
        write_ch(8'h3C);
        chk(buf_lvl == 1'b0, "R7 one sel1", int'(buf_lvl), 0);
        chk(tx_done == 1'b0, "R8 not done", int'(tx_done), 0);
        lvl_sel = 1'b0; #1;
        chk(buf_lvl == 1'b1, "R7 one sel0", int'(buf_lvl), 1);
        write_ch(8'h5A);
        chk(buf_lvl == 1'b0, "R7 full sel0", int'(buf_lvl), 0);
        write_ch(8'hFF);  // dropped
        pulse_en();
        rx_frame(8'h3C, 8, 0, 2, 1'b0, "R6 first");
        rx_frame(8'h5A, 8, 0, 2, 1'b1, "R6 second");
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, "R6 third dropped", int'(quiet), 1);
        chk(tx_done == 1'b1, "R8 done", int'(tx_done), 1);
    endtask

    task automatic t_disable();
        bit quiet = 1'b1;
        cfg = mkcfg(8, 0, 1);
        write_ch(8'h96);
        write_ch(8'h69);
        fork
            rx_frame(8'h96, 8, 0, 2, 1'b0, "R10 finish");
            begin repeat (12) @(negedge clk); pulse_dis(); end
        join
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, "R10 idle after frame", int'(quiet), 1);
        chk(tx_on == 1'b0, "R10 off", int'(tx_on), 0);
        chk(tx_done == 1'b0, "R10 kept", int'(tx_done), 0);
        chk(buf_lvl == 1'b1, "R10 one left", int'(buf_lvl), 1);
        pulse_en();
        rx_frame(8'h69, 8, 0, 2, 1'b1, "R10 resume");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_formats();
        t_level_drop();
        t_disable();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule